// File: doc/BRIEF.md
# Legacy VGA Access Router

This block sits on the request path of a host bridge and decides, one request at a time, whether a memory or I/O access falls inside the legacy display windows. It also decides whether that access belongs to the on-chip graphics engine or should travel on to the downstream bridge path. The decision uses the address, the access type and a handful of configuration bits. These are the device enable, the VGA enable, the memory- and I/O-space enables, the two low bits of the miscellaneous output register and the two-bit memory map mode.

The memory window A0000h–BFFFFh is split into three sub-windows. The map mode picks which of them the graphics engine owns. The I/O windows are the monochrome and colour port groups. Bit 0 of the miscellaneous output register selects which of those two groups the graphics engine claims. I/O ports are compared over the full address, so aliases of the legacy ports never match.

Each request is decoded in a single combinational stage. The result is registered, so the route and the hit flag appear one clock after the request strobe, together with an output valid.

Top module: `vga_route_top`

## Requirements
- R1: After a cycle with `rst` high, `rsp_valid`, `rsp_hit` and `rsp_to_gfx` are all 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_hit` and `rsp_to_gfx` are 0 whenever `rsp_valid` is 0.
- R3: A memory request (`req_is_io`=0) is a hit exactly when the full address lies in A0000h–BFFFFh, whatever the enables are. Any higher address bit set makes it a miss.
- R4: A memory request routes to graphics (`rsp_to_gfx`=1) only if `cfg_dev_en`, `cfg_vga_en`, `cfg_mem_en` and `cfg_misc[1]` are all 1. Otherwise a hit goes to the bridge (`rsp_to_gfx`=0). `cfg_io_en` plays no part.
- R5: With all memory enables set and `cfg_map_mode`=00, the whole range A0000h–BFFFFh routes to graphics.
- R6: With all memory enables set, map mode 01 gives graphics only A0000h–AFFFFh. Mode 10 gives it only B0000h–B7FFFh, and mode 11 only B8000h–BFFFFh. The other sub-windows route to the bridge.
- R7: An I/O request (`req_is_io`=1) is a hit exactly when the full address is in 3B0h–3BBh or 3C0h–3DFh. Aliases such as 7C0h or 103C0h are misses.
- R8: An I/O request routes to graphics only if `cfg_dev_en`, `cfg_vga_en` and `cfg_io_en` are all 1. `cfg_mem_en` and `cfg_misc[1]` play no part.
- R9: With the I/O enables set and `cfg_misc[0]`=0, ports 3C0h–3CFh and 3B0h–3BBh route to graphics, and 3D0h–3DFh route to the bridge.
- R10: With the I/O enables set and `cfg_misc[0]`=1, ports 3C0h–3CFh and 3D0h–3DFh route to graphics, and 3B0h–3BBh route to the bridge.
- R11: I/O ports 3BCh–3BFh are a miss routed to the bridge for either value of `cfg_misc[0]`.
- R12: Every miss reports `rsp_to_gfx`=0, which is the bridge default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| req_addr | input | ADDR_W (32) | Request address |
| cfg_dev_en | input | 1 | Graphics device enabled |
| cfg_vga_en | input | 1 | Graphics VGA function enabled |
| cfg_mem_en | input | 1 | Graphics memory-space decode enabled |
| cfg_io_en | input | 1 | Graphics I/O-space decode enabled |
| cfg_misc | input | 2 | Misc output register: bit 1 memory enable, bit 0 I/O select |
| cfg_map_mode | input | 2 | Memory map mode |
| rsp_valid | output | 1 | Registered decision valid |
| rsp_to_gfx | output | 1 | 1 = graphics engine, 0 = bridge path |
| rsp_hit | output | 1 | Request fell in a legacy window |

## Verification
Two situations are hard to reach from the ports. One is an address that aliases a legacy port or window only in its high bits. The other is an enable combination where exactly one of the required bits is clear while the rest are set. The stimulus table covers both directly. It walks each enable clear in turn with an in-window address, and it includes I/O ports with bit 10, bit 12 or bit 16 set beside their true counterparts. Directed steps then cover idle cycles, back-to-back requests and a reset asserted while a response is pending.

// File: rtl/vga_route_pkg.sv
package vga_route_pkg;

  // Memory sub-windows; bit i of a sub-window vector refers to entry i
  localparam int NUM_MEM_WIN = 3;
  localparam int SEG_W       = 20;

  typedef logic [SEG_W-1:0] seg_addr_t;

  localparam seg_addr_t MEM_WIN_LO [NUM_MEM_WIN] = '{20'hA0000, 20'hB0000, 20'hB8000};
  localparam seg_addr_t MEM_WIN_HI [NUM_MEM_WIN] = '{20'hAFFFF, 20'hB7FFF, 20'hBFFFF};

  // I/O port groups
  localparam int PORT_W = 12;
  typedef logic [PORT_W-1:0] port_t;

  localparam port_t MONO_LO  = 12'h3B0;
  localparam port_t MONO_HI  = 12'h3BB;
  localparam port_t COLC_LO  = 12'h3C0;
  localparam port_t COLC_HI  = 12'h3CF;
  localparam port_t COLD_LO  = 12'h3D0;
  localparam port_t COLD_HI  = 12'h3DF;

  typedef enum logic [1:0] {
    MAP_WHOLE = 2'b00,
    MAP_LOW64 = 2'b01,
    MAP_MONO  = 2'b10,
    MAP_COLOR = 2'b11
  } map_mode_e;

  // Which sub-windows the graphics engine owns for a given map mode
  function automatic logic [NUM_MEM_WIN-1:0] owned_windows(input map_mode_e mode);
    logic [NUM_MEM_WIN-1:0] m;
    case (mode)
      MAP_WHOLE: m = '1;
      MAP_LOW64: m = 3'b001;
      MAP_MONO:  m = 3'b010;
      default:   m = 3'b100;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vga_mem_dec.sv
module vga_mem_dec
  import vga_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic [NUM_MEM_WIN-1:0] sub_hit,
  output logic                   any_hit
);

  localparam int EXT_W = ADDR_W - SEG_W;

  for (genvar i = 0; i < NUM_MEM_WIN; i++) begin : g_win
    logic [ADDR_W-1:0] lo_w, hi_w;
    assign lo_w = {{EXT_W{1'b0}}, MEM_WIN_LO[i]};
    assign hi_w = {{EXT_W{1'b0}}, MEM_WIN_HI[i]};
    assign sub_hit[i] = (addr >= lo_w) && (addr <= hi_w);
  end

  assign any_hit = |sub_hit;

  // sub-windows are disjoint
  always_comb begin
    disjoint_win_chk: assert ($onehot0(sub_hit) || $isunknown(sub_hit))
      else $error("memory sub-window overlap");
  end

endmodule

// File: rtl/vga_io_dec.sv
module vga_io_dec
  import vga_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_mono,
  output logic              in_col_c,
  output logic              in_col_d,
  output logic              any_hit
);

  localparam int EXT_W = ADDR_W - PORT_W;

  // Full-width compares: any set high bit falls outside every range
  function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                    input port_t lo, input port_t hi);
    return (a >= {{EXT_W{1'b0}}, lo}) && (a <= {{EXT_W{1'b0}}, hi});
  endfunction

  assign in_mono  = in_range(addr, MONO_LO, MONO_HI);
  assign in_col_c = in_range(addr, COLC_LO, COLC_HI);
  assign in_col_d = in_range(addr, COLD_LO, COLD_HI);
  assign any_hit  = in_mono | in_col_c | in_col_d;

endmodule

// File: rtl/vga_route_reg.sv
module vga_route_reg (
  input  logic clk,
  input  logic rst,
  input  logic valid_in,
  input  logic gfx_in,
  input  logic hit_in,
  output logic valid_q,
  output logic gfx_q,
  output logic hit_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      gfx_q   <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_in;
      gfx_q   <= valid_in & gfx_in;
      hit_q   <= valid_in & hit_in;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !valid_q && !gfx_q && !hit_q)
    else $error("R1 outputs not idle after reset");

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst) valid_in |=> valid_q)
    else $error("R2 missing response");

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst) !valid_in |=> !valid_q && !gfx_q && !hit_q)
    else $error("R2 response without request");

endmodule

// File: rtl/vga_route_top.sv
module vga_route_top
  import vga_route_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_dev_en,
  input  logic              cfg_vga_en,
  input  logic              cfg_mem_en,
  input  logic              cfg_io_en,
  input  logic [1:0]        cfg_misc,
  input  logic [1:0]        cfg_map_mode,
  output logic              rsp_valid,
  output logic              rsp_to_gfx,
  output logic              rsp_hit
);

  logic [NUM_MEM_WIN-1:0] mem_sub;
  logic                   mem_hit;
  logic                   io_mono, io_col_c, io_col_d, io_hit;
  logic                   mem_allowed, io_allowed;
  logic                   mem_gfx, io_gfx;
  logic                   gfx_d, hit_d;

  vga_mem_dec #(.ADDR_W(ADDR_W)) u_mem (
    .addr    (req_addr),
    .sub_hit (mem_sub),
    .any_hit (mem_hit)
  );

  vga_io_dec #(.ADDR_W(ADDR_W)) u_io (
    .addr     (req_addr),
    .in_mono  (io_mono),
    .in_col_c (io_col_c),
    .in_col_d (io_col_d),
    .any_hit  (io_hit)
  );

  assign mem_allowed = cfg_dev_en & cfg_vga_en & cfg_mem_en & cfg_misc[1];
  assign io_allowed  = cfg_dev_en & cfg_vga_en & cfg_io_en;

  assign mem_gfx = mem_allowed & |(mem_sub & owned_windows(map_mode_e'(cfg_map_mode)));
  assign io_gfx  = io_allowed & (io_col_c | (io_col_d & cfg_misc[0]) | (io_mono & ~cfg_misc[0]));

  assign hit_d = req_is_io ? io_hit : mem_hit;
  assign gfx_d = req_is_io ? io_gfx : mem_gfx;

  vga_route_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .valid_in (req_valid),
    .gfx_in   (gfx_d),
    .hit_in   (hit_d),
    .valid_q  (rsp_valid),
    .gfx_q    (rsp_to_gfx),
    .hit_q    (rsp_hit)
  );

  // R12
  miss_to_bridge_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid && !rsp_hit |-> !rsp_to_gfx)
    else $error("R12 miss routed to graphics");

  // R4
  mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && !req_is_io && !(cfg_dev_en && cfg_vga_en && cfg_mem_en && cfg_misc[1]) |=> !rsp_to_gfx)
    else $error("R4 memory routed to graphics while disabled");

  // R8
  io_gate_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_is_io && !(cfg_dev_en && cfg_vga_en && cfg_io_en) |=> !rsp_to_gfx)
    else $error("R8 I/O routed to graphics while disabled");

  // R11
  mda_ports_bridge_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid && req_is_io && (req_addr >= ADDR_W'(12'h3BC)) && (req_addr <= ADDR_W'(12'h3BF))
      |=> rsp_valid && !rsp_hit && !rsp_to_gfx)
    else $error("R11 ports 3BC-3BF not sent to bridge");

endmodule

// File: tb/sim_vga_route_top.sv
`timescale 1ns/1ps
module sim_vga_route_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_is_io;
  logic [31:0] req_addr;
  logic        cfg_dev_en, cfg_vga_en, cfg_mem_en, cfg_io_en;
  logic [1:0]  cfg_misc, cfg_map_mode;
  logic        rsp_valid, rsp_to_gfx, rsp_hit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vga_route_top #(.ADDR_W(32)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .cfg_dev_en(cfg_dev_en), .cfg_vga_en(cfg_vga_en),
    .cfg_mem_en(cfg_mem_en), .cfg_io_en(cfg_io_en), .cfg_misc(cfg_misc),
    .cfg_map_mode(cfg_map_mode), .rsp_valid(rsp_valid), .rsp_to_gfx(rsp_to_gfx),
    .rsp_hit(rsp_hit)
  );

  // Vector: {is_io, addr[31:0], en{dev,vga,mem,io}, misc[1:0], mode[1:0], exp_hit, exp_gfx, req#[3:0]}
  localparam int NV = 46;
  localparam logic [46:0] VEC [NV] = '{
    // R5 mode 00
    {1'b0, 32'h000A0000, 4'hF, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},
    {1'b0, 32'h000AFFFF, 4'hF, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},
    {1'b0, 32'h000B0000, 4'hF, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},
    {1'b0, 32'h000BFFFF, 4'hF, 2'b11, 2'b00, 1'b1, 1'b1, 4'd5},
    // R6 mode 01
    {1'b0, 32'h000A1234, 4'hF, 2'b11, 2'b01, 1'b1, 1'b1, 4'd6},
    {1'b0, 32'h000B0000, 4'hF, 2'b11, 2'b01, 1'b1, 1'b0, 4'd6},
    {1'b0, 32'h000B8000, 4'hF, 2'b11, 2'b01, 1'b1, 1'b0, 4'd6},
    // R6 mode 10
    {1'b0, 32'h000B7FFF, 4'hF, 2'b11, 2'b10, 1'b1, 1'b1, 4'd6},
    {1'b0, 32'h000AFFFF, 4'hF, 2'b11, 2'b10, 1'b1, 1'b0, 4'd6},
    {1'b0, 32'h000B8000, 4'hF, 2'b11, 2'b10, 1'b1, 1'b0, 4'd6},
    // R6 mode 11
    {1'b0, 32'h000B8000, 4'hF, 2'b11, 2'b11, 1'b1, 1'b1, 4'd6},
    {1'b0, 32'h000B7FFF, 4'hF, 2'b11, 2'b11, 1'b1, 1'b0, 4'd6},
    {1'b0, 32'h000A0000, 4'hF, 2'b11, 2'b11, 1'b1, 1'b0, 4'd6},
    // R4 one enable clear at a time
    {1'b0, 32'h000A0000, 4'h7, 2'b11, 2'b00, 1'b1, 1'b0, 4'd4},
    {1'b0, 32'h000A0000, 4'hB, 2'b11, 2'b00, 1'b1, 1'b0, 4'd4},
    {1'b0, 32'h000A0000, 4'hD, 2'b11, 2'b00, 1'b1, 1'b0, 4'd4},
    {1'b0, 32'h000A0000, 4'hF, 2'b01, 2'b00, 1'b1, 1'b0, 4'd4},
    {1'b0, 32'h000A0000, 4'hE, 2'b10, 2'b00, 1'b1, 1'b1, 4'd4},
    // R3 memory misses and aliases
    {1'b0, 32'h0009FFFF, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd3},
    {1'b0, 32'h000C0000, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd3},
    {1'b0, 32'h100A0000, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd3},
    {1'b0, 32'h000003C0, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd3},
    {1'b0, 32'h000B8000, 4'h0, 2'b00, 2'b00, 1'b1, 1'b0, 4'd3},
    // R9 select 0
    {1'b1, 32'h000003C0, 4'hF, 2'b10, 2'b00, 1'b1, 1'b1, 4'd9},
    {1'b1, 32'h000003CF, 4'hF, 2'b10, 2'b00, 1'b1, 1'b1, 4'd9},
    {1'b1, 32'h000003B0, 4'hF, 2'b10, 2'b00, 1'b1, 1'b1, 4'd9},
    {1'b1, 32'h000003BB, 4'hF, 2'b10, 2'b00, 1'b1, 1'b1, 4'd9},
    {1'b1, 32'h000003D0, 4'hF, 2'b10, 2'b00, 1'b1, 1'b0, 4'd9},
    {1'b1, 32'h000003DF, 4'hF, 2'b10, 2'b00, 1'b1, 1'b0, 4'd9},
    // R10 select 1
    {1'b1, 32'h000003C5, 4'hF, 2'b01, 2'b00, 1'b1, 1'b1, 4'd10},
    {1'b1, 32'h000003D4, 4'hF, 2'b01, 2'b00, 1'b1, 1'b1, 4'd10},
    {1'b1, 32'h000003B4, 4'hF, 2'b01, 2'b00, 1'b1, 1'b0, 4'd10},
    {1'b1, 32'h000003BB, 4'hF, 2'b01, 2'b00, 1'b1, 1'b0, 4'd10},
    // R11 ports 3BC-3BF
    {1'b1, 32'h000003BC, 4'hF, 2'b10, 2'b00, 1'b0, 1'b0, 4'd11},
    {1'b1, 32'h000003BF, 4'hF, 2'b10, 2'b00, 1'b0, 1'b0, 4'd11},
    {1'b1, 32'h000003BD, 4'hF, 2'b01, 2'b00, 1'b0, 1'b0, 4'd11},
    // R8 I/O gating
    {1'b1, 32'h000003C0, 4'hE, 2'b11, 2'b00, 1'b1, 1'b0, 4'd8},
    {1'b1, 32'h000003C0, 4'h7, 2'b11, 2'b00, 1'b1, 1'b0, 4'd8},
    {1'b1, 32'h000003C0, 4'hB, 2'b11, 2'b00, 1'b1, 1'b0, 4'd8},
    {1'b1, 32'h000003C0, 4'hB, 2'b11, 2'b00, 1'b1, 1'b0, 4'd8},
    {1'b1, 32'h000003C0, 4'hD, 2'b00, 2'b00, 1'b1, 1'b1, 4'd8},
    // R7 I/O aliases and edges
    {1'b1, 32'h000007C0, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd7},
    {1'b1, 32'h000013B0, 4'hF, 2'b10, 2'b00, 1'b0, 1'b0, 4'd7},
    {1'b1, 32'h000103C0, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd7},
    {1'b1, 32'h000003AF, 4'hF, 2'b10, 2'b00, 1'b0, 1'b0, 4'd7},
    // R12 memory window address on an I/O request is a miss
    {1'b1, 32'h000A0000, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd12}
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s {valid,hit,gfx} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_is_io = 1'b0; req_addr = '0;
    {cfg_dev_en, cfg_vga_en, cfg_mem_en, cfg_io_en} = 4'hF;
    cfg_misc = 2'b11; cfg_map_mode = 2'b00;
  endtask

  task automatic apply(input logic [46:0] v);
    req_valid = 1'b1;
    req_is_io = v[46];
    req_addr  = v[45:14];
    {cfg_dev_en, cfg_vga_en, cfg_mem_en, cfg_io_en} = v[13:10];
    cfg_misc     = v[9:8];
    cfg_map_mode = v[7:6];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b000);
    rst = 1'b0;
    @(negedge clk);
    // R2: no request, no response
    check("R2 idle", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b000);

    // Table walk: response is sampled one clock after the strobe
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i),
            {rsp_valid, rsp_hit, rsp_to_gfx}, {1'b1, VEC[i][5], VEC[i][4]});
      req_valid = 1'b0;
    end

    // R2: after the last request the response drops and clears its fields
    @(negedge clk);
    check("R2 drop after request", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b000);

    // R2: back-to-back requests, each answered in the following cycle
    apply({1'b1, 32'h000003C0, 4'hF, 2'b10, 2'b00, 1'b1, 1'b1, 4'd2});
    @(negedge clk);
    check("R2 back-to-back first", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b111);
    apply({1'b0, 32'h000C8000, 4'hF, 2'b11, 2'b00, 1'b0, 1'b0, 4'd2});
    @(negedge clk);
    check("R2 back-to-back second", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b100);
    apply({1'b0, 32'h000B0000, 4'hF, 2'b11, 2'b10, 1'b1, 1'b1, 4'd2});
    @(negedge clk);
    check("R2 back-to-back third", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b111);

    // R1: reset while a request is presented clears the pending response
    apply({1'b0, 32'h000A0000, 4'hF, 2'b11, 2'b00, 1'b1, 1'b1, 4'd1});
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset during request", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b000);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {rsp_valid, rsp_hit, rsp_to_gfx}, 3'b000);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule